// File: doc/BRIEF.md
# Delay-Slot Fetch and Next-PC Sequencer

This block fetches instructions for a small 32-bit scalar core with a single branch delay slot and works out which program counter comes next. The instruction window is a 4 KiB region that sits at byte offset 0x1000 of the core's local memory. The current word is read combinationally at that offset plus the PC, with the most significant byte at the lowest address. The opcode class fields of the word are decoded into a dispatch class and a dispatch index for the execute stage.

Each cycle the block is busy, one instruction executes. The execute stage answers in that same cycle with a branch outcome code and, for a taken branch, a target. A taken or untaken branch always runs its delay slot before any redirect. A discard outcome skips one instruction. An exception outcome leaves the PC where it is. After every update the PC is forced to a word-aligned value inside the 4 KiB window.

A run request starts execution from the current PC and clears the retired-instruction counter. A halt request stops execution at once. A break flag stops execution only when no delay slot is pending.

Top module: `dslot_pc_seq`

## Requirements
- R1: After reset the PC is 0, busy is low, both delay-slot outputs are low and the retired count is 0.
- R2: The fetched word is built from local bytes 0x1000+PC (bits 31:24) through 0x1000+PC+3 (bits 7:0). A byte write whose address bit 12 is 0 lies outside the window and does not change any fetched word.
- R3: An executed instruction with outcome code 0 (no branch; codes 5 to 7 behave the same) advances the PC by 4. The PC wraps from 0xFFC to 0x000.
- R4: Outcome code 1 (taken) captures the target with its two low bits cleared and advances the PC by 4. The next instruction is flagged as a taken delay slot (in_dslot and in_dslot_taken high). After that instruction the PC becomes the target.
- R5: Outcome code 2 (not taken) advances the PC by 4 and flags the next instruction as a delay slot with in_dslot_taken low. After the slot the PC advances by 4 again.
- R6: Outcome code 3 (discard) advances the PC by 8.
- R7: Outcome code 4 (exception) leaves the PC unchanged and returns to normal stepping. Inside a delay slot it cancels the pending redirect.
- R8: While a delay slot executes, outcome codes other than 4 have no effect.
- R9: A halt request drops busy on the next edge, with no PC change and no instruction counted. While busy is low the PC holds.
- R10: Once a break flag has been seen during a run, execution stops after the first instruction whose update leaves no delay slot pending, so a pending slot always completes.
- R11: The retired count rises by one per executed instruction. A run request while idle starts execution and clears the count. A run request while busy is ignored.
- R12: Dispatch class and index follow the major opcode in bits 31:26. Opcode 0 gives class 1 with index bits 5:0. Opcode 1 gives class 2 with bits 20:16. Opcode 16 gives class 3 and opcode 18 gives class 4, both with bits 25:21. Opcode 50 gives class 5 and opcode 58 gives class 6, both with bits 15:11. Any other opcode gives class 0 with the opcode as the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Start a run from the current PC |
| halt_req | input | 1 | Stop immediately |
| brk_flag | input | 1 | Break raised by the current instruction |
| br_kind | input | 3 | Outcome of the current instruction (0 none, 1 taken, 2 not taken, 3 discard, 4 exception) |
| br_target | input | PC_W | Branch target, used with outcome 1 |
| im_we | input | 1 | Local memory byte write enable |
| im_addr | input | PC_W+1 | Local memory byte address |
| im_wdata | input | 8 | Byte to write |
| busy | output | 1 | Executing |
| pc | output | PC_W | Current program counter |
| instr | output | 32 | Fetched word at the current PC |
| disp_class | output | 3 | Dispatch class |
| disp_idx | output | 6 | Dispatch index |
| in_dslot | output | 1 | Current instruction is a delay slot |
| in_dslot_taken | output | 1 | Current instruction is the slot of a taken branch |
| retired | output | CNT_W | Instructions executed in this run |

## Verification
Some behaviour is checked on every cycle by properties. A halt freezes the PC and clears busy. An idle block holds its PC. Each executed instruction raises the count by exactly one. A delay slot never follows another delay slot. A taken slot ends at the captured target unless an exception cancels it. Busy never falls while a slot is pending except through halt. Other behaviour only the bench's scenarios can show. These are the big-endian fetch and the ignored write outside the window, the decode of each opcode class, and the discard skip. They also include the wrap at the top of the window, ignored outcomes inside a slot, count clearing on a new run, and the two break cases, where the stop comes on a plain instruction or only after a slot.

// File: rtl/dslot_pc_seq.sv
`timescale 1ns/1ps
module dslot_pc_seq #(
  parameter int PC_W  = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             halt_req,
  input  logic             brk_flag,
  input  logic [2:0]       br_kind,
  input  logic [PC_W-1:0]  br_target,
  input  logic             im_we,
  input  logic [PC_W:0]    im_addr,
  input  logic [7:0]       im_wdata,
  output logic             busy,
  output logic [PC_W-1:0]  pc,
  output logic [31:0]      instr,
  output logic [2:0]       disp_class,
  output logic [5:0]       disp_idx,
  output logic             in_dslot,
  output logic             in_dslot_taken,
  output logic [CNT_W-1:0] retired
);
  localparam int WIN_BYTES = 1 << PC_W;
  localparam logic [PC_W-1:0] ALIGN = ~PC_W'(3);

  typedef enum logic [2:0] {
    S_STEP, S_TAKE, S_NT, S_DST, S_DSNT, S_DISC, S_EXC
  } bst_t;

  logic [7:0]      mem [WIN_BYTES];
  bst_t            st, eff, nst;
  logic [PC_W-1:0] tgt_q, npc;
  logic            running, broken, exec, start, brk_now;

  always_ff @(posedge clk)
    if (im_we && im_addr[PC_W])
      mem[im_addr[PC_W-1:0]] <= im_wdata;

  assign instr = {mem[{pc[PC_W-1:2], 2'd0}], mem[{pc[PC_W-1:2], 2'd1}],
                  mem[{pc[PC_W-1:2], 2'd2}], mem[{pc[PC_W-1:2], 2'd3}]};

  always_comb begin
    disp_class = 3'd0;
    disp_idx   = instr[31:26];
    case (instr[31:26])
      6'd0:  begin disp_class = 3'd1; disp_idx = instr[5:0]; end
      6'd1:  begin disp_class = 3'd2; disp_idx = {1'b0, instr[20:16]}; end
      6'd16: begin disp_class = 3'd3; disp_idx = {1'b0, instr[25:21]}; end
      6'd18: begin disp_class = 3'd4; disp_idx = {1'b0, instr[25:21]}; end
      6'd50: begin disp_class = 3'd5; disp_idx = {1'b0, instr[15:11]}; end
      6'd58: begin disp_class = 3'd6; disp_idx = {1'b0, instr[15:11]}; end
      default: ;
    endcase
  end

  assign busy           = running;
  assign exec           = running && !halt_req;
  assign start          = !running && run_req && !halt_req;
  assign brk_now        = broken || brk_flag;
  assign in_dslot       = (st == S_DST) || (st == S_DSNT);
  assign in_dslot_taken = (st == S_DST);

  always_comb begin
    eff = st;
    if (st == S_STEP) begin
      case (br_kind)
        3'd1: eff = S_TAKE;
        3'd2: eff = S_NT;
        3'd3: eff = S_DISC;
        3'd4: eff = S_EXC;
        default: eff = S_STEP;
      endcase
    end else if (br_kind == 3'd4) begin
      eff = S_EXC;
    end
  end

  always_comb begin
    nst = S_STEP;
    npc = pc + PC_W'(4);
    case (eff)
      S_TAKE: nst = S_DST;
      S_NT:   nst = S_DSNT;
      S_DST:  npc = tgt_q;
      S_DISC: npc = pc + PC_W'(8);
      S_EXC:  npc = pc;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_STEP;
      pc      <= '0;
      tgt_q   <= '0;
      running <= 1'b0;
      broken  <= 1'b0;
      retired <= '0;
    end else begin
      if (exec) begin
        st      <= nst;
        pc      <= npc & ALIGN;
        retired <= retired + CNT_W'(1);
        if (eff == S_TAKE) tgt_q <= br_target & ALIGN;
        if (brk_flag) broken <= 1'b1;
      end
      if (start) begin
        retired <= '0;
        broken  <= 1'b0;
      end
      if (halt_req)                              running <= 1'b0;
      else if (start)                            running <= 1'b1;
      else if (exec && brk_now && nst == S_STEP) running <= 1'b0;
    end
  end

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (!busy && pc == $past(pc)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> pc == $past(pc));
  // R11
  retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !halt_req) |=> retired == $past(retired) + CNT_W'(1));
  // R5
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !halt_req && in_dslot) |=> !in_dslot);
  // R4
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !halt_req && in_dslot_taken && br_kind != 3'd4) |=> pc == $past(tgt_q));
  // R10
  stop_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(halt_req) || !in_dslot));
endmodule

// File: tb/test_dslot_pc_seq.sv
`timescale 1ns/1ps
module test_dslot_pc_seq;
  localparam int PC_W = 12, CNT_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run_req, halt_req, brk_flag, im_we;
  logic [2:0] br_kind;
  logic [PC_W-1:0] br_target;
  logic [PC_W:0] im_addr;
  logic [7:0] im_wdata;
  logic busy, in_dslot, in_dslot_taken;
  logic [PC_W-1:0] pc;
  logic [31:0] instr;
  logic [2:0] disp_class;
  logic [5:0] disp_idx;
  logic [CNT_W-1:0] retired;

  dslot_pc_seq #(.PC_W(PC_W), .CNT_W(CNT_W)) i_dslot_pc_seq (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .halt_req(halt_req),
    .brk_flag(brk_flag), .br_kind(br_kind), .br_target(br_target),
    .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata), .busy(busy),
    .pc(pc), .instr(instr), .disp_class(disp_class), .disp_idx(disp_idx),
    .in_dslot(in_dslot), .in_dslot_taken(in_dslot_taken), .retired(retired));

  typedef struct {
    int    pc;
    bit    busy, ds, dt;
    int    cnt;
    string tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  logic [7:0] bm [4096];
  int mpc = 0, mst = 0, mtgt = 0, mcnt = 0;
  bit mbusy = 0, mbrk = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] word_at(input int p);
    return {bm[p], bm[p+1], bm[p+2], bm[p+3]};
  endfunction

  function automatic logic [8:0] dec(input logic [31:0] w);
    case (w[31:26])
      6'd0:  return {3'd1, w[5:0]};
      6'd1:  return {3'd2, 1'b0, w[20:16]};
      6'd16: return {3'd3, 1'b0, w[25:21]};
      6'd18: return {3'd4, 1'b0, w[25:21]};
      6'd50: return {3'd5, 1'b0, w[15:11]};
      6'd58: return {3'd6, 1'b0, w[15:11]};
      default: return {3'd0, w[31:26]};
    endcase
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    im_we = 1'b1; im_addr = (PC_W+1)'(a); im_wdata = d;
    @(negedge clk);
    im_we = 1'b0;
  endtask

  task automatic wword(input int p, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      wr(32'h1000 + p + b, w[31-8*b -: 8]);
      bm[p+b] = w[31-8*b -: 8];
    end
  endtask

  task automatic cyc(input bit h, input bit r, input logic [2:0] k, input int t, input bit b, input string tag);
    bit ex, pre;
    int eff, nst;
    exp_t e;
    @(negedge clk);
    halt_req = h; run_req = r; br_kind = k; br_target = PC_W'(t); brk_flag = b;
    pre = mbusy;
    ex = mbusy && !h;
    if (ex) begin
      if (mst == 0) eff = (k >= 3'd1 && k <= 3'd4) ? int'(k) : 0;
      else if (k == 3'd4) eff = 4;
      else eff = (mst == 1) ? 5 : 6;
      nst = 0;
      case (eff)
        1: begin mtgt = t & 'hFFC; mpc += 4; nst = 1; end
        2: begin mpc += 4; nst = 2; end
        3: mpc += 8;
        4: ;
        5: mpc = mtgt;
        default: mpc += 4;
      endcase
      mpc &= 'hFFC;
      mcnt = (mcnt + 1) & 'hFFFF;
      if (b) mbrk = 1;
      if (mbrk && nst == 0) mbusy = 0;
      mst = nst;
    end
    if (h) mbusy = 0;
    else if (r && !pre) begin mbusy = 1; mcnt = 0; mbrk = 0; end
    e.pc = mpc; e.busy = mbusy; e.ds = (mst != 0); e.dt = (mst == 1); e.cnt = mcnt; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      exp_t e;
      logic [31:0] w;
      logic [8:0] d;
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        w = word_at(e.pc);
        d = dec(w);
        chk(e.tag, "pc", 32'(pc), e.pc);
        chk(e.tag, "busy", 32'(busy), 32'(e.busy));
        chk(e.tag, "in_dslot", 32'(in_dslot), 32'(e.ds));
        chk(e.tag, "in_dslot_taken", 32'(in_dslot_taken), 32'(e.dt));
        chk(e.tag, "retired", 32'(retired), e.cnt);
        chk("R2", "instr", instr, w);
        chk("R12", "disp", {23'd0, disp_class, disp_idx}, {23'd0, d});
      end
    end
  end

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_req = 0; halt_req = 0; brk_flag = 0; br_kind = 0;
    br_target = 0; im_we = 0; im_addr = 0; im_wdata = 0;
    for (int i = 0; i < 4096; i++) bm[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "pc", 32'(pc), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "in_dslot", 32'(in_dslot), 0);
    chk("R1", "retired", 32'(retired), 0);
    for (int i = 0; i < 4096; i++) wr(32'h1000 + i, 8'h00);
    wword(0,  32'h0000_0025);
    wword(4,  32'h0411_0000);
    wword(8,  32'h4080_0000);
    wword(12, 32'h48C0_0000);
    wword(16, 32'hC800_2000);
    wword(20, 32'hE800_5800);
    wword(24, 32'h8C00_0000);
    wr(32'h0004, 8'hFF); // R2: outside the window, no effect
    cyc(0, 1, 0, 0, 0, "R11");
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, 0, "R12");
    cyc(0, 0, 1, 'h100, 0, "R4");
    cyc(0, 0, 1, 'h200, 0, "R8");
    cyc(0, 0, 2, 0, 0, "R5");
    cyc(0, 0, 3, 0, 0, "R8");
    cyc(0, 0, 3, 0, 0, "R6");
    cyc(0, 0, 4, 0, 0, "R7");
    cyc(0, 0, 1, 'h303, 0, "R4");
    cyc(0, 0, 4, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 'hFF8, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R3");
    cyc(0, 1, 0, 0, 0, "R11");
    cyc(1, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, "R11");
    cyc(0, 0, 0, 0, 0, "R11");
    cyc(0, 0, 1, 'h40, 1, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    cyc(0, 1, 0, 0, 0, "R11");
    cyc(0, 0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    repeat (3) @(posedge clk);
    #5;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule